// File: doc/BRIEF.md
# Port-Triggered SMI Request Controller

This block sits on the chipset side of a system and raises system management interrupt (SMI) requests toward the processor. It decodes a small, fixed window of a 16-bit I/O-space bus: a command byte whose write fires an SMI, a parameter byte that software fills in before firing so the handler can learn what was asked, a configuration byte for a periodic SMI source, an acknowledge/pending byte, and a read-only count of delivered SMIs.

Requests come from two places: a software write to the command byte, and a periodic timer that fires every 8, 16, 32 or 64 seconds once enabled. Requests cannot be masked. The SMI output is a level that stays high until the handler acknowledges it; requests that arrive in the meantime merge into the one already pending. An NMI request input passes through the same output stage, and is dropped whenever an SMI trigger occurs in the same cycle.

Top module: `smi_port_ctrl`

## Requirements
- R1: After reset smi_o and nmi_o are low and every register (command, parameter, configuration, pending flag, delivery count) reads as zero.
- R2: A bus write to word address 0xB2 with io_be[0]=1 stores io_wdata[7:0] as the command byte (read back in io_rdata[7:0] at 0xB2) and drives smi_o high on the next clock edge, whatever the configuration holds.
- R3: A bus write to word address 0xB2 with io_be=2'b10 (the byte at 0xB3) stores io_wdata[15:8] as the parameter byte (read back in io_rdata[15:8]) and does not raise smi_o.
- R4: A 16-bit write (io_be=2'b11) to 0xB2 updates both bytes in one access and counts as exactly one SMI delivery.
- R5: smi_o stays high until a write to word 0xB4 with io_be[1]=1 and io_wdata[8]=1; writing 0 in that bit leaves it high. io_rdata[8] at 0xB4 reads the pending level.
- R6: A trigger that arrives while smi_o is already high keeps it high and does not change the delivery count.
- R7: The delivery count, read as io_rdata at word 0xB6, increments by one on each rising edge of smi_o and by nothing else.
- R8: Configuration byte at word 0xB4 lane 0: bit 0 enables the periodic source, bits 2:1 select the interval (00=64 s, 01=32 s, 10=16 s, 11=8 s, one second being CLK_PER_SEC clocks); smi_o rises exactly interval x CLK_PER_SEC clock edges after the configuration write, and never while the enable is clear.
- R9: Any write to the configuration byte restarts the periodic timer from zero.
- R10: nmi_o is nmi_req delayed by one clock, except that it is forced low for a cycle in which an SMI trigger (port write or periodic tick) occurs.
- R11: io_addr[0] is ignored; writes with io_be=2'b00, writes to unmapped addresses and reads (io_wr=0) change no register and raise no SMI.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address; bit 0 ignored, word aligned |
| io_be | input | 2 | Byte enables, bit 0 even byte, bit 1 odd byte |
| io_wdata | input | 16 | Write data |
| io_wr | input | 1 | Write strobe, one access per cycle high |
| io_rdata | output | 16 | Read data for io_addr, combinational |
| nmi_req | input | 1 | NMI request from other chipset logic |
| smi_o | output | 1 | SMI level to the processor |
| nmi_o | output | 1 | Forwarded NMI |

## Verification
The bench goes after the byte-lane split at 0xB2/0xB3: a design that fired on any write in the pair would raise SMI on a parameter-only write, and one that counted per byte would record two deliveries for a 16-bit access. It retriggers while the level is high and writes a zero acknowledge, where a design counting every trigger or clearing on any acknowledge write would show a wrong count or a dropped level. The periodic source is timed to the exact edge for three intervals and after a mid-period restart, catching off-by-one prescalers, a reversed interval encoding and a timer that ignores rewrites. A simultaneous NMI and port write checks that the NMI is suppressed rather than passed alongside.

// File: rtl/smi_pkg.sv
package smi_pkg;
  localparam logic [14:0] WA_APM = 15'h0059; // bytes 0xB2/0xB3
  localparam logic [14:0] WA_CFG = 15'h005A; // bytes 0xB4/0xB5
  localparam logic [14:0] WA_CNT = 15'h005B; // bytes 0xB6/0xB7

  typedef struct packed {
    logic [1:0] sel;
    logic       en;
  } per_cfg_t;
endpackage

// File: rtl/smi_regs.sv
module smi_regs
  import smi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic [1:0]  io_be,
  input  logic [15:0] io_wdata,
  input  logic        io_wr,
  input  logic        smi_lvl,
  input  logic [15:0] cnt_rd,
  output logic [15:0] io_rdata,
  output per_cfg_t    cfg,
  output logic        apm_trig,
  output logic        ack,
  output logic        cfg_wr
);
  logic [7:0] cmd_q, cmd_d;
  logic [7:0] par_q, par_d;
  per_cfg_t   cfg_q, cfg_d;
  logic       hit_apm, hit_cfg, hit_cnt;

  assign hit_apm = (io_addr[15:1] == WA_APM);
  assign hit_cfg = (io_addr[15:1] == WA_CFG);
  assign hit_cnt = (io_addr[15:1] == WA_CNT);

  // strobes toward the trigger and timer logic
  assign apm_trig = io_wr && hit_apm && io_be[0];
  assign cfg_wr   = io_wr && hit_cfg && io_be[0];
  assign ack      = io_wr && hit_cfg && io_be[1] && io_wdata[8];
  assign cfg      = cfg_q;

  always_comb begin
    cmd_d = cmd_q;
    par_d = par_q;
    cfg_d = cfg_q;
    if (io_wr && hit_apm && io_be[0]) cmd_d = io_wdata[7:0];
    if (io_wr && hit_apm && io_be[1]) par_d = io_wdata[15:8];
    if (cfg_wr)                       cfg_d = per_cfg_t'(io_wdata[2:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      par_q <= '0;
      cfg_q <= '0;
    end else begin
      cmd_q <= cmd_d;
      par_q <= par_d;
      cfg_q <= cfg_d;
    end
  end

  always_comb begin
    io_rdata = '0;
    if (hit_apm)      io_rdata = {par_q, cmd_q};
    else if (hit_cfg) io_rdata = {7'b0, smi_lvl, 5'b0, cfg_q};
    else if (hit_cnt) io_rdata = cnt_rd;
  end

  AST_PAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && hit_apm && io_be[1]) |=> $stable(par_q)); // R3
  AST_IDLE_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> ($stable(cmd_q) && $stable(cfg_q))); // R11
endmodule

// File: rtl/smi_period_timer.sv
module smi_period_timer
  import smi_pkg::*;
#(
  parameter int CLK_PER_SEC = 100_000_000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  per_cfg_t cfg,
  input  logic     restart,
  output logic     tick
);
  localparam int PW = (CLK_PER_SEC > 1) ? $clog2(CLK_PER_SEC) : 1;
  localparam logic [PW-1:0] PLAST = PW'(CLK_PER_SEC - 1);
  localparam int SW = 7;

  logic [PW-1:0] pre_q, pre_d;
  logic [SW-1:0] sec_q, sec_d;
  logic [SW-1:0] lim;
  logic          sec_end;

  always_comb begin
    case (cfg.sel)
      2'b00:   lim = 7'd64;
      2'b01:   lim = 7'd32;
      2'b10:   lim = 7'd16;
      default: lim = 7'd8;
    endcase
  end

  assign sec_end = (pre_q == PLAST);
  assign tick    = cfg.en && !restart && sec_end && (sec_q == lim - 7'd1);

  always_comb begin
    pre_d = pre_q;
    sec_d = sec_q;
    if (restart || !cfg.en) begin
      pre_d = '0;
      sec_d = '0;
    end else if (sec_end) begin
      pre_d = '0;
      sec_d = tick ? '0 : sec_q + 7'd1;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      sec_q <= '0;
    end else begin
      pre_q <= pre_d;
      sec_q <= sec_d;
    end
  end

  AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |-> !tick); // R8
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pre_q == '0 && sec_q == '0)); // R9
endmodule

// File: rtl/smi_out_arb.sv
module smi_out_arb #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             ack,
  input  logic             nmi_req,
  output logic             smi_o,
  output logic             nmi_o,
  output logic [CNT_W-1:0] cnt
);
  logic             smi_q, smi_d;
  logic             nmi_q, nmi_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             deliver;

  // a new delivery only when no request is already pending
  assign deliver = trig && !smi_q;

  always_comb begin
    smi_d = smi_q;
    if (ack)  smi_d = 1'b0;
    if (trig) smi_d = 1'b1;
    nmi_d = nmi_req && !trig;
    cnt_d = deliver ? cnt_q + 1'b1 : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smi_q <= 1'b0;
      nmi_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      smi_q <= smi_d;
      nmi_q <= nmi_d;
      cnt_q <= cnt_d;
    end
  end

  assign smi_o = smi_q;
  assign nmi_o = nmi_q;
  assign cnt   = cnt_q;

  AST_SMI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_o && !ack) |=> smi_o); // R5
  AST_NMI_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !nmi_o); // R10
  AST_CNT_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_o && trig) |=> $stable(cnt)); // R6
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smi_o) |-> (cnt == $past(cnt) + 1'b1)); // R7
endmodule

// File: rtl/smi_port_ctrl.sv
module smi_port_ctrl
  import smi_pkg::*;
#(
  parameter int CLK_PER_SEC = 100_000_000,
  parameter int CNT_W       = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic [1:0]  io_be,
  input  logic [15:0] io_wdata,
  input  logic        io_wr,
  output logic [15:0] io_rdata,
  input  logic        nmi_req,
  output logic        smi_o,
  output logic        nmi_o
);
  per_cfg_t         cfg;
  logic             apm_trig, ack, cfg_wr, tick, trig;
  logic [CNT_W-1:0] cnt;
  logic [15:0]      cnt_rd;

  assign cnt_rd = 16'(cnt);
  assign trig   = apm_trig || tick;

  smi_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_be    (io_be),
    .io_wdata (io_wdata),
    .io_wr    (io_wr),
    .smi_lvl  (smi_o),
    .cnt_rd   (cnt_rd),
    .io_rdata (io_rdata),
    .cfg      (cfg),
    .apm_trig (apm_trig),
    .ack      (ack),
    .cfg_wr   (cfg_wr)
  );

  smi_period_timer #(.CLK_PER_SEC(CLK_PER_SEC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg     (cfg),
    .restart (cfg_wr),
    .tick    (tick)
  );

  smi_out_arb #(.CNT_W(CNT_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig    (trig),
    .ack     (ack),
    .nmi_req (nmi_req),
    .smi_o   (smi_o),
    .nmi_o   (nmi_o),
    .cnt     (cnt)
  );

  AST_B3_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr[15:1] == WA_APM && io_be == 2'b10 && !tick && !smi_o)
    |=> !smi_o); // R3
  AST_PORT_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr[15:1] == WA_APM && io_be[0]) |=> smi_o); // R2
endmodule

// File: tb/sim_smi_port_ctrl.sv
module sim_smi_port_ctrl;
  localparam int CPS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic [1:0]  io_be = '0;
  logic [15:0] io_wdata = '0;
  logic        io_wr = 1'b0;
  logic [15:0] io_rdata;
  logic        nmi_req = 1'b0;
  logic        smi_o, nmi_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  smi_port_ctrl #(.CLK_PER_SEC(CPS), .CNT_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_be(io_be),
    .io_wdata(io_wdata), .io_wr(io_wr), .io_rdata(io_rdata),
    .nmi_req(nmi_req), .smi_o(smi_o), .nmi_o(nmi_o)
  );

  // {addr, be(4), wdata, exp_smi(4), exp_cnt(8), exp_rd_b2}
  localparam logic [63:0] VEC [6] = '{
    {16'h00B2, 4'h1, 16'h0012, 4'h1, 8'd1, 16'h0012},  // R2
    {16'h00B2, 4'h2, 16'h3400, 4'h0, 8'd1, 16'h3412},  // R3
    {16'h00B2, 4'h3, 16'h5678, 4'h1, 8'd2, 16'h5678},  // R4
    {16'h00B2, 4'h0, 16'hFFFF, 4'h0, 8'd2, 16'h5678},  // R11
    {16'h00C0, 4'h3, 16'hFFFF, 4'h0, 8'd2, 16'h5678},  // R11
    {16'h00B3, 4'h2, 16'h9A00, 4'h0, 8'd2, 16'h9A78}   // R11 addr bit 0
  };

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [15:0] a, logic [1:0] be, logic [15:0] d);
    @(negedge clk);
    io_addr = a; io_be = be; io_wdata = d; io_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    io_wr = 1'b0; io_be = '0;
  endtask

  task automatic bus_rd(logic [15:0] a, output logic [15:0] d);
    io_addr = a; io_wr = 1'b0;
    #1 d = io_rdata;
  endtask

  task automatic ack_smi();
    bus_wr(16'h00B4, 2'b10, 16'h0100);
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    logic [15:0] rd;
    logic [15:0] c0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 smi", {15'b0, smi_o}, 16'h0);
    chk("R1 nmi", {15'b0, nmi_o}, 16'h0);
    bus_rd(16'h00B2, rd); chk("R1 apm", rd, 16'h0);
    bus_rd(16'h00B4, rd); chk("R1 cfg", rd, 16'h0);
    bus_rd(16'h00B6, rd); chk("R1 cnt", rd, 16'h0);

    // table walk
    for (int k = 0; k < 6; k++) begin
      bus_wr(VEC[k][63:48], VEC[k][45:44], VEC[k][43:28]);
      chk($sformatf("R2/R3/R4/R11 vec%0d smi", k), {15'b0, smi_o}, {15'b0, VEC[k][24]});
      bus_rd(16'h00B6, rd); chk($sformatf("R7 vec%0d cnt", k), rd, {8'b0, VEC[k][23:16]});
      bus_rd(16'h00B2, rd); chk($sformatf("R2 vec%0d readback", k), rd, VEC[k][15:0]);
      ack_smi();
      chk($sformatf("R5 vec%0d ack", k), {15'b0, smi_o}, 16'h0);
    end

    // R5 zero ack keeps level; pending readable
    bus_wr(16'h00B2, 2'b01, 16'h0001);
    bus_wr(16'h00B4, 2'b10, 16'h0000);
    chk("R5 zero ack holds", {15'b0, smi_o}, 16'h1);
    bus_rd(16'h00B4, rd); chk("R5 pending bit", rd, 16'h0100);
    // R6 merge
    bus_wr(16'h00B2, 2'b11, 16'h0002);
    bus_wr(16'h00B2, 2'b01, 16'h0003);
    bus_rd(16'h00B6, rd); chk("R6 merged count", rd, 16'd3);
    ack_smi();
    chk("R5 ack clears", {15'b0, smi_o}, 16'h0);

    // R11 reads have no side effects
    for (int i = 0; i < 4; i++) begin bus_rd(16'h00B2, rd); @(negedge clk); end
    chk("R11 read quiet smi", {15'b0, smi_o}, 16'h0);
    bus_rd(16'h00B6, rd); chk("R11 read quiet cnt", rd, 16'd3);

    // R10 NMI pass and drop
    @(negedge clk); nmi_req = 1'b1;
    @(negedge clk); nmi_req = 1'b0;
    chk("R10 nmi pass", {15'b0, nmi_o}, 16'h1);
    @(negedge clk);
    io_addr = 16'h00B2; io_be = 2'b01; io_wdata = 16'h0004; io_wr = 1'b1; nmi_req = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_be = '0; nmi_req = 1'b0;
    chk("R10 nmi dropped", {15'b0, nmi_o}, 16'h0);
    chk("R10 smi wins", {15'b0, smi_o}, 16'h1);
    ack_smi();

    // R8 periodic, three intervals
    for (int s = 0; s < 3; s++) begin
      logic [1:0] sel;
      int lim;
      sel = (s == 0) ? 2'b11 : (s == 1) ? 2'b01 : 2'b00;
      lim = (s == 0) ? 8 : (s == 1) ? 32 : 64;
      bus_rd(16'h00B6, c0);
      bus_wr(16'h00B4, 2'b01, {13'b0, sel, 1'b1});
      wait_cyc(lim * CPS - 1);
      chk($sformatf("R8 sel%0d early", sel), {15'b0, smi_o}, 16'h0);
      wait_cyc(1);
      chk($sformatf("R8 sel%0d fire", sel), {15'b0, smi_o}, 16'h1);
      bus_rd(16'h00B6, rd); chk($sformatf("R7 periodic cnt sel%0d", sel), rd, c0 + 16'd1);
      bus_wr(16'h00B4, 2'b01, 16'h0000);
      ack_smi();
    end
    // R8 disabled never fires
    wait_cyc(80 * CPS);
    chk("R8 disabled", {15'b0, smi_o}, 16'h0);

    // R9 restart on cfg write
    bus_wr(16'h00B4, 2'b01, 16'h0007);
    wait_cyc(20);
    bus_wr(16'h00B4, 2'b01, 16'h0007);
    wait_cyc(8 * CPS - 1);
    chk("R9 restart early", {15'b0, smi_o}, 16'h0);
    wait_cyc(1);
    chk("R9 restart fire", {15'b0, smi_o}, 16'h1);
    bus_wr(16'h00B4, 2'b01, 16'h0000);
    ack_smi();

    finish_run();
  end
endmodule